// File: doc/BRIEF.md
# Timer Compare/Capture Channel Pair

This block sits beside a free-running counter and gives it two data slots, A and B, that share one control word. Each slot works either as a comparator, which flags every cycle in which the counter equals the stored value, or as a capture latch. A capture latch copies the counter when its own external pin shows the chosen edge. Two waveform outputs are driven by a small state machine per output. That machine sets, resets or toggles the output level on compare hits from slot A and/or slot B, and an invert bit reverses the pin polarity.

Six event flags record compare hits and captures. Two of them are overwrite flags, raised when a capture arrives before software has acknowledged the previous one. Software clears a flag by writing a one to it. Each flag has its own enable bit, and the single interrupt request is the OR of the enabled flags. A plain register bus reaches the control word, both data slots, the enable register and the flag register. The counter itself, any prescaler and the interrupt controller sit outside the block.

Waveform state machine, one per output. The states are `WV_OFF` (output mode is 0 and the pin is held at its inactive level), `WV_LOW` and `WV_HIGH`. The transitions are:
- OFF→LOW when the mode becomes non-zero.
- LOW→HIGH on the set condition.
- HIGH→LOW on the reset condition.
- LOW/HIGH→OFF when the mode returns to 0.

Top module: `tmr_ccpair`

## Requirements
- R1: After reset every readable register reads 0, both waveform outputs are 0 and `irq` is 0.
- R2: Register addresses: 0 is the control word, 1 is data A, 2 is data B, 3 is the interrupt enable register and 4 is the flag register. The control word holds the following fields, and bits 11–10 and 3–2 read as 0:

  | Bits | Field |
  |------|-------|
  | 15–14 | B capture trigger |
  | 13–12 | B output mode |
  | 9 | B invert |
  | 8 | B slot mode |
  | 7–6 | A capture trigger |
  | 5–4 | A output mode |
  | 1 | A invert |
  | 0 | A slot mode |

  A written value therefore reads back masked with 0xF3F3.
- R3: A slot in compare mode (slot mode bit = 0) sets its compare flag (bit 0 for A, bit 1 for B) at the clock edge that ends a cycle in which `cnt_val` equals the slot value.
- R4: Output mode 1 drives the level high on a compare A hit and low on a compare B hit. When both hit in the same cycle, the level ends high.
- R5: Output mode 2 toggles the level on each compare A hit. Output mode 3 toggles it on each compare B hit. The new level appears one clock edge after the hit cycle.
- R6: Output mode 0 holds the level low. The output pin equals the level XOR the invert bit in every mode.
- R7: A slot in capture mode (slot mode bit = 1) loads `cnt_val` on the trigger selected by its 2-bit field: 0 captures nothing, 1 captures on rising edges, 2 on falling edges and 3 on both. The load happens on the third clock edge after the pin changes, and the value loaded is the counter present at that edge.
- R8: A capture sets its capture flag (bit 2 for A, bit 3 for B). If that flag is already set, the capture also sets the overwrite flag (bit 4 for A, bit 5 for B), and the new value replaces the old.
- R9: A slot in capture mode never sets its compare flag. A slot in compare mode ignores its capture pin.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R11: `irq` is 1 exactly when some flag bit is 1 together with the enable bit at the same position. The enable register holds 6 bits (bits 5..0), and its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Free-running counter value |
| cap_a_in | input | 1 | Capture pin for slot A (asynchronous) |
| cap_b_in | input | 1 | Capture pin for slot B (asynchronous) |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several properties on every cycle:
- the off-mode pin level against the invert bit;
- the captured value against the counter at the load edge;
- the raising of overwrite flags;
- the precedence of a hardware set over a write-one clear.

Only the bench scenarios can show the full waveform sequences for each output mode under random compare values. They also show trigger selection per edge polarity, the isolation between compare and capture modes, and the interrupt gating seen through the bus.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    typedef enum logic [1:0] {
        WV_OFF  = 2'd0,
        WV_LOW  = 2'd1,
        WV_HIGH = 2'd2
    } wave_state_t;

    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int NUM_FLAG = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA0 = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_DATA1 = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd4;

    localparam int FL_CMP0 = 0;
    localparam int FL_CMP1 = 1;
    localparam int FL_CAP0 = 2;
    localparam int FL_CAP1 = 3;
    localparam int FL_OVW0 = 4;
    localparam int FL_OVW1 = 5;
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] trig,
    output logic       evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= cur;
        end
    end

    // bit 0 of trig selects rising edges, bit 1 selects falling edges
    assign evt = (trig[0] & cur & ~prev_q) | (trig[1] & ~cur & prev_q);
endmodule

// File: rtl/ccp_wave.sv
module ccp_wave
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       inv,
    input  logic       hit_a,
    input  logic       hit_b,
    output logic       wave
);
    wave_state_t state_q, state_d;
    logic        go_high, go_low;

    always_comb begin
        unique case (mode)
            2'd1:    begin go_high = hit_a; go_low = hit_b & ~hit_a; end
            2'd2:    begin go_high = hit_a; go_low = hit_a;          end
            2'd3:    begin go_high = hit_b; go_low = hit_b;          end
            default: begin go_high = 1'b0;  go_low = 1'b0;           end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WV_OFF:  if (mode != 2'd0) state_d = WV_LOW;
            WV_LOW:  if (mode == 2'd0) state_d = WV_OFF;
                     else if (go_high) state_d = WV_HIGH;
            WV_HIGH: if (mode == 2'd0) state_d = WV_OFF;
                     else if (go_low)  state_d = WV_LOW;
            default: state_d = WV_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WV_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        wave = (state_q == WV_HIGH) ^ inv;
    end
endmodule

// File: rtl/tmr_ccpair.sv
module tmr_ccpair
    import ccp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cap_a_in,
    input  logic              cap_b_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq
);
    localparam int NCH = 2;

    logic [NCH-1:0][1:0]       cap_trig;
    logic [NCH-1:0][1:0]       out_mode;
    logic [NCH-1:0]            out_inv;
    logic [NCH-1:0]            cap_mode;
    logic [NCH-1:0][CNT_W-1:0] data_q;
    logic [NUM_FLAG-1:0]       irq_en;
    logic [NUM_FLAG-1:0]       flags_q;
    logic [NUM_FLAG-1:0]       flag_set;
    logic [NUM_FLAG-1:0]       flag_clr;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            cap_evt;
    logic [NCH-1:0]            raw_evt;
    logic [NCH-1:0]            wave;
    logic [NCH-1:0]            pins;
    logic                      wr;

    assign wr   = bus_sel & bus_we;
    assign pins = {cap_b_in, cap_a_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_trig <= '0;
            out_mode <= '0;
            out_inv  <= '0;
            cap_mode <= '0;
        end else if (wr && bus_addr == ADR_CTRL) begin
            cap_trig[1] <= bus_wdata[15:14];
            out_mode[1] <= bus_wdata[13:12];
            out_inv[1]  <= bus_wdata[9];
            cap_mode[1] <= bus_wdata[8];
            cap_trig[0] <= bus_wdata[7:6];
            out_mode[0] <= bus_wdata[5:4];
            out_inv[0]  <= bus_wdata[1];
            cap_mode[0] <= bus_wdata[0];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADR = (ch == 0) ? ADR_DATA0 : ADR_DATA1;

        ccp_capture #(.SYNC_STAGES(SYNC_STAGES)) i_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[ch]),
            .trig (cap_trig[ch]),
            .evt  (raw_evt[ch])
        );

        assign cap_evt[ch] = raw_evt[ch] & cap_mode[ch];
        assign hit[ch]     = ~cap_mode[ch] & (cnt_val == data_q[ch]);

        // a capture outranks a bus write in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       data_q[ch] <= '0;
            else if (cap_evt[ch])             data_q[ch] <= cnt_val;
            else if (wr && bus_addr == MY_ADR) data_q[ch] <= bus_wdata[CNT_W-1:0];
        end

        ccp_wave i_wave (
            .clk  (clk),
            .rst_n(rst_n),
            .mode (out_mode[ch]),
            .inv  (out_inv[ch]),
            .hit_a(hit[0]),
            .hit_b(hit[1]),
            .wave (wave[ch])
        );
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];

    assign flag_set = {cap_evt[1] & flags_q[FL_CAP1],
                       cap_evt[0] & flags_q[FL_CAP0],
                       cap_evt[1], cap_evt[0], hit[1], hit[0]};
    assign flag_clr = (wr && bus_addr == ADR_FLAG) ? bus_wdata[NUM_FLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_en  <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            if (wr && bus_addr == ADR_IEN) irq_en <= bus_wdata[NUM_FLAG-1:0];
        end
    end

    assign irq = |(flags_q & irq_en);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL:  bus_rdata = {cap_trig[1], out_mode[1], 2'b00, out_inv[1], cap_mode[1],
                                    cap_trig[0], out_mode[0], 2'b00, out_inv[0], cap_mode[0]};
            ADR_DATA0: bus_rdata = BUS_W'(data_q[0]);
            ADR_DATA1: bus_rdata = BUS_W'(data_q[1]);
            ADR_IEN:   bus_rdata = BUS_W'(irq_en);
            ADR_FLAG:  bus_rdata = BUS_W'(flags_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CNT_W-1:0]      cnt_val,
    input logic [1:0]            cap_evt,
    input logic [1:0][CNT_W-1:0] data_q,
    input logic [5:0]            flags_q,
    input logic [5:0]            flag_set,
    input logic [5:0]            flag_clr,
    input logic [1:0][1:0]       out_mode,
    input logic [1:0]            out_inv,
    input logic                  wave_a,
    input logic                  wave_b
);
    AST_OFF_PIN_A: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_mode[0]) == 2'd0 && out_mode[0] == 2'd0) |-> wave_a == out_inv[0]); // R6
    AST_OFF_PIN_B: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_mode[1]) == 2'd0 && out_mode[1] == 2'd0) |-> wave_b == out_inv[1]); // R6
    AST_CAP_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt[0] |=> data_q[0] == $past(cnt_val)); // R7
    AST_CAP_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt[1] |=> data_q[1] == $past(cnt_val)); // R7
    AST_OVW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[0] && flags_q[2]) |=> flags_q[4]); // R8
    AST_OVW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[1] && flags_q[3]) |=> flags_q[5]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != 6'd0) |=> (flags_q & $past(flag_set)) == $past(flag_set)); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~flag_set) != 6'd0) |=> (flags_q & $past(flag_clr & ~flag_set)) == 6'd0); // R10
endmodule

bind tmr_ccpair ccp_checker #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .cap_evt (cap_evt),
    .data_q  (data_q),
    .flags_q (flags_q),
    .flag_set(flag_set),
    .flag_clr(flag_clr),
    .out_mode(out_mode),
    .out_inv (out_inv),
    .wave_a  (wave_a),
    .wave_b  (wave_b)
);

// File: tb/test_tmr_ccpair.sv
module test_tmr_ccpair;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'hFFFF;
    logic        cap_a = 1'b0, cap_b = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        wave_a, wave_b, irq;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ccpair i_tmr_ccpair (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cap_a_in(cap_a), .cap_b_in(cap_b),
        .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int wave_next(input int s, input logic [1:0] m, input logic ha, input logic hb);
        logic up, dn;
        up = (m == 2'd3) ? hb : ha;
        dn = (m == 2'd1) ? (hb & ~ha) : (m == 2'd2) ? ha : hb;
        if (m == 2'd0) return 0;
        if (s == 0) return 1;
        if (s == 1) return up ? 2 : 1;
        return dn ? 1 : 2;
    endfunction

    function automatic logic [15:0] ctrl_view(input logic [15:0] w);
        return w & 16'hF3F3;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            chk("R1 reg", r, 16'h0);
        end
        chk("R1 wave/irq", {13'd0, wave_a, wave_b, irq}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 layout and reserved bits
        wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R2 ctrl", r, ctrl_view(16'hFFFF));
        wr(3'd0, 16'h5A5A); rd(3'd0, r); chk("R2 ctrl", r, ctrl_view(16'h5A5A));
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h1111); rd(3'd1, r); chk("R2 dataA", r, 16'h1111);
        wr(3'd2, 16'h2222); rd(3'd2, r); chk("R2 dataB", r, 16'h2222);
        wr(3'd5, 16'hFFFF); rd(3'd5, r); chk("R2 unmapped", r, 16'h0);
        // R11 enable width
        wr(3'd3, 16'hFFFF); rd(3'd3, r); chk("R11 ien", r, 16'h003F);
        wr(3'd3, 16'h0000);

        // R6 invert in off mode
        wr(3'd0, 16'h0202); @(negedge clk);
        chk("R6 off inv", {14'd0, wave_a, wave_b}, 16'h3);
        wr(3'd0, 16'h0000); @(negedge clk);
        chk("R6 off", {14'd0, wave_a, wave_b}, 16'h0);

        // R4/R5 random compare sequences
        for (int it = 0; it < 40; it++) begin
            logic [15:0] va, vb, c;
            int sa, sb, na, nb;
            logic ha, hb;
            va = 16'(1 + $urandom_range(0, 40));
            vb = (it % 5 == 0) ? va : 16'(1 + $urandom_range(0, 40));
            c  = {2'b00, 2'($urandom_range(1, 3)), 2'b00, 1'($urandom), 1'b0,
                  2'b00, 2'($urandom_range(1, 3)), 2'b00, 1'($urandom), 1'b0};
            cnt = 16'hFFFF;
            wr(3'd0, 16'h0000);
            wr(3'd1, va);
            wr(3'd2, vb);
            wr(3'd0, c);
            sa = 0; sb = 0;
            for (int t = 0; t < 64; t++) begin
                cnt = 16'(t);
                ha = (cnt == va); hb = (cnt == vb);
                na = wave_next(sa, c[5:4], ha, hb);
                nb = wave_next(sb, c[13:12], ha, hb);
                @(posedge clk);
                @(negedge clk);
                sa = na; sb = nb;
                chk((c[5:4] == 2'd1) ? "R4 wave A" : "R5 wave A", {15'd0, wave_a},
                    {15'd0, (sa == 2) ^ c[1]});
                chk((c[13:12] == 2'd1) ? "R4 wave B" : "R5 wave B", {15'd0, wave_b},
                    {15'd0, (sb == 2) ^ c[9]});
            end
        end
        cnt = 16'hFFFF;
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h003F);
        rd(3'd4, r); chk("R10 clear all", r, 16'h0);

        // R3 compare flag and R11 irq gating
        wr(3'd1, 16'd5); wr(3'd2, 16'd9);
        cnt = 16'd5; @(negedge clk); cnt = 16'd100;
        rd(3'd4, r); chk("R3 cmpA flag", r, 16'h0001);
        chk("R11 irq off", {15'd0, irq}, 16'h0);
        wr(3'd3, 16'h0001);
        chk("R11 irq on", {15'd0, irq}, 16'h1);
        wr(3'd3, 16'h0002);
        chk("R11 irq masked", {15'd0, irq}, 16'h0);
        // R10 write 0 no effect, write 1 clears
        wr(3'd4, 16'h0000); rd(3'd4, r); chk("R10 w0", r, 16'h0001);
        wr(3'd4, 16'h0001); rd(3'd4, r); chk("R10 w1", r, 16'h0000);
        // R10 set beats clear: counter held on match
        cnt = 16'd9;
        wr(3'd4, 16'h0002); cnt = 16'd100;
        rd(3'd4, r); chk("R10 set wins", r, 16'h0002);
        wr(3'd4, 16'h003F);

        // R7 capture A rising only
        cnt = 16'h1234;
        wr(3'd0, 16'h0041);
        @(negedge clk); cap_a = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd1, r); chk("R7 cap rise", r, 16'h1234);
        rd(3'd4, r); chk("R8 cap flag", r, 16'h0004);
        cnt = 16'h2222; cap_a = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd1, r); chk("R7 fall ignored", r, 16'h1234);
        // R8 overwrite with both-edge trigger
        wr(3'd0, 16'h00C1);
        cnt = 16'h3333; cap_a = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd1, r); chk("R8 new value", r, 16'h3333);
        rd(3'd4, r); chk("R8 overwrite", r, 16'h0014);
        // R9 capture slot ignores counter match
        wr(3'd4, 16'h003F);
        cnt = 16'h3333; repeat (2) @(negedge clk); cnt = 16'h0100;
        rd(3'd4, r); chk("R9 no cmp in cap", r, 16'h0000);
        // R7 B falling, trigger 2
        cnt = 16'h4444;
        cap_b = 1'b1; wr(3'd0, 16'h8100); repeat (4) @(negedge clk);
        rd(3'd2, r); chk("R7 B no rise", r, 16'h0009);
        cap_b = 1'b0; repeat (5) @(negedge clk);
        rd(3'd2, r); chk("R7 B fall", r, 16'h4444);
        // R7 trigger 0 captures nothing
        wr(3'd0, 16'h0100); cnt = 16'h5555;
        cap_b = 1'b1; repeat (5) @(negedge clk); cap_b = 1'b0; repeat (5) @(negedge clk);
        rd(3'd2, r); chk("R7 trig none", r, 16'h4444);
        // R9 compare slot ignores its pin
        wr(3'd0, 16'hC000); wr(3'd4, 16'h003F);
        cap_b = 1'b1; repeat (5) @(negedge clk);
        rd(3'd2, r); chk("R9 cmp ignores pin", r, 16'h4444);
        rd(3'd4, r); chk("R9 no cap flag", r, 16'h0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule